// File: doc/BRIEF.md
# Switchable Inclusion-Mode Data-Flow Controller

This block sits between a private second-level cache (L2) and a shared last-level cache (L3). It decides where a line goes for each cache event. There are four kinds of event: a clean victim leaving L2, a dirty victim leaving L2, a line fill returning from memory, and a hit in L3. For each event the block raises control strobes that the cache controllers act on. The strobes are: write the victim into L3, install the line in L2, install the line in L3, invalidate the line in L3, and discard. A one-bit mode input selects the handling. When the bit is low the hierarchy is non-inclusive. When the bit is high it is exclusive.

The mode can change on any cycle. No flush or clean-up step is needed: lines already resident are simply handled under the rules of the mode that is current when their next event arrives. An extra bypass input applies only in exclusive mode. It lets clean victims skip L3, which cuts insertion traffic. The block also keeps two saturating event counts: lines written into L3, and lines discarded. A policy monitor elsewhere can read these counts.

Top module: `incl_flow_ctrl`

## Requirements
- R1: With the mode bit at 0, a clean victim (kind code 0) raises only the discard strobe.
- R2: With the mode bit at 0, a memory fill (kind code 2) raises both install-in-L2 and install-in-L3, and nothing else.
- R3: With the mode bit at 0, an L3 hit (kind code 3) raises only install-in-L2. The L3 copy stays valid.
- R4: With the mode bit at 1 and bypass at 0, a clean victim raises only the write-into-L3 strobe.
- R5: With the mode bit at 1, a memory fill raises only install-in-L2.
- R6: With the mode bit at 1, an L3 hit raises install-in-L2 together with invalidate-in-L3, and nothing else.
- R7: A dirty victim (kind code 1) raises only the write-into-L3 strobe, whatever the mode and bypass bits are.
- R8: With the mode bit at 1 and bypass at 1, a clean victim raises only the discard strobe. The bypass bit has no effect on any other event kind, and it has no effect in mode 0.
- R9: Strobes and the address output are registered. They reflect the event accepted at the previous rising clock edge. A cycle without a valid event leaves every strobe low on the next cycle.
- R10: The mode and bypass bits are sampled in the same cycle as the event. Back-to-back events with different mode values are each handled under their own mode, with no idle cycle and no flush.
- R11: The insertion count rises by one for each event that raises write-into-L3 or install-in-L3. The discard count rises by one for each discard. Both counts update together with the strobes, and both hold at their maximum value of 2^CNT_W-1 instead of wrapping.
- R12: While reset is asserted, all strobes, the address output and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_valid_i | input | 1 | One-cycle event pulse |
| ev_kind_i | input | 2 | Event kind: 0 clean victim, 1 dirty victim, 2 memory fill, 3 L3 hit |
| ev_addr_i | input | ADDR_W | Line address of the event |
| excl_mode_i | input | 1 | 0 selects non-inclusive handling, 1 selects exclusive handling |
| bypass_i | input | 1 | In exclusive mode, discard clean victims instead of writing them into L3 |
| l3_insert_o | output | 1 | Write the L2 victim into L3 |
| l2_install_o | output | 1 | Install the line in L2 |
| l3_install_o | output | 1 | Install the fill in L3 |
| l3_inval_o | output | 1 | Invalidate the hitting line in L3 |
| drop_o | output | 1 | Discard the victim |
| addr_o | output | ADDR_W | Address of the event the strobes belong to |
| ins_cnt_o | output | CNT_W | Saturating count of L3 insertions |
| drop_cnt_o | output | CNT_W | Saturating count of discards |

## Verification
The bench builds the block with CNT_W=3 and ADDR_W=8. With only three count bits, each counter saturates after a handful of events. This lets the bench reach the hold-at-maximum behaviour for both counts and check that the strobes keep working past that point. The eight-bit address lets every event carry a distinct tag, so the bench can confirm that the registered address belongs to the event whose strobes appear alongside it, including during back-to-back mode switches.

// File: rtl/incl_flow_pkg.sv
package incl_flow_pkg;
  typedef enum logic [1:0] {
    EV_CLEAN_VIC = 2'd0,
    EV_DIRTY_VIC = 2'd1,
    EV_MEM_FILL  = 2'd2,
    EV_LLC_HIT   = 2'd3
  } ev_kind_e;

  typedef struct packed {
    logic l3_insert;
    logic l2_install;
    logic l3_install;
    logic l3_inval;
    logic drop;
  } route_t;
endpackage

// File: rtl/route_decode.sv
module route_decode
  import incl_flow_pkg::*;
(
  input  logic     valid_i,
  input  ev_kind_e kind_i,
  input  logic     excl_i,
  input  logic     bypass_i,
  output route_t   route_o
);
  always_comb begin
    route_o = '0;
    if (valid_i) begin
      unique case (kind_i)
        EV_CLEAN_VIC: begin
          if (excl_i && !bypass_i) route_o.l3_insert = 1'b1;
          else                     route_o.drop      = 1'b1;
        end
        EV_DIRTY_VIC: route_o.l3_insert = 1'b1;
        EV_MEM_FILL: begin
          route_o.l2_install = 1'b1;
          route_o.l3_install = !excl_i;
        end
        EV_LLC_HIT: begin
          route_o.l2_install = 1'b1;
          route_o.l3_inval   = excl_i;
        end
        default: route_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MaxVal = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (inc_i && cnt_o != MaxVal) cnt_o <= cnt_o + 1'b1;
  end

  assert_sat_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MaxVal) |=> (cnt_o == MaxVal));
  assert_step_one_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != MaxVal) |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/incl_flow_ctrl.sv
module incl_flow_ctrl
  import incl_flow_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [1:0]        ev_kind_i,
  input  logic [ADDR_W-1:0] ev_addr_i,
  input  logic              excl_mode_i,
  input  logic              bypass_i,
  output logic              l3_insert_o,
  output logic              l2_install_o,
  output logic              l3_install_o,
  output logic              l3_inval_o,
  output logic              drop_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  ins_cnt_o,
  output logic [CNT_W-1:0]  drop_cnt_o
);
  localparam int NumCnt = 2;

  route_t route_d, route_q;

  route_decode i_route_decode (
    .valid_i  (ev_valid_i),
    .kind_i   (ev_kind_e'(ev_kind_i)),
    .excl_i   (excl_mode_i),
    .bypass_i (bypass_i),
    .route_o  (route_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
      addr_o  <= '0;
    end else begin
      route_q <= route_d;
      if (ev_valid_i) addr_o <= ev_addr_i;
    end
  end

  assign l3_insert_o  = route_q.l3_insert;
  assign l2_install_o = route_q.l2_install;
  assign l3_install_o = route_q.l3_install;
  assign l3_inval_o   = route_q.l3_inval;
  assign drop_o       = route_q.drop;

  // counters advance on the same edge that registers the strobes
  logic [NumCnt-1:0] cnt_inc;
  logic [CNT_W-1:0]  cnt_val [NumCnt];

  assign cnt_inc[0] = route_d.l3_insert | route_d.l3_install;
  assign cnt_inc[1] = route_d.drop;

  for (genvar g = 0; g < NumCnt; g++) begin : g_cnt
    sat_counter #(.W(CNT_W)) i_sat_counter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (cnt_inc[g]),
      .cnt_o  (cnt_val[g])
    );
  end

  assign ins_cnt_o  = cnt_val[0];
  assign drop_cnt_o = cnt_val[1];

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_valid_i |=> !(l3_insert_o | l2_install_o | l3_install_o | l3_inval_o | drop_o));
  assert_drop_alone_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> !(l3_insert_o | l2_install_o | l3_install_o | l3_inval_o));
  assert_fill_l3_noninc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && excl_mode_i) |=> !l3_install_o);
  assert_inval_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !excl_mode_i) |=> !l3_inval_o);
  assert_inval_pairs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l3_inval_o |-> (l2_install_o && !l3_install_o));
  assert_dirty_insert_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_kind_i == 2'd1) |=> (l3_insert_o && !drop_o));
endmodule

// File: tb/test_incl_flow_ctrl.sv
module test_incl_flow_ctrl;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 3;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [1:0] ev_kind = '0;
  logic [ADDR_W-1:0] ev_addr = '0;
  logic excl = 1'b0;
  logic byp = 1'b0;
  logic l3_ins, l2_inst, l3_inst, l3_inv, drp;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0] ins_cnt, drop_cnt;

  int checks = 0;
  int errors = 0;
  int exp_ins = 0;
  int exp_drop = 0;
  bit done = 0;

  always #5 clk = ~clk;

  incl_flow_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_incl_flow_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_kind_i(ev_kind),
    .ev_addr_i(ev_addr), .excl_mode_i(excl), .bypass_i(byp),
    .l3_insert_o(l3_ins), .l2_install_o(l2_inst), .l3_install_o(l3_inst),
    .l3_inval_o(l3_inv), .drop_o(drp), .addr_o(addr),
    .ins_cnt_o(ins_cnt), .drop_cnt_o(drop_cnt)
  );

  // expected strobes {l3_insert, l2_install, l3_install, l3_inval, drop}
  function automatic logic [4:0] expect_route(input logic [1:0] k, input logic m, input logic b);
    case (k)
      2'd0:    return (m && !b) ? 5'b10000 : 5'b00001;
      2'd1:    return 5'b10000;
      2'd2:    return m ? 5'b01000 : 5'b01100;
      default: return m ? 5'b01010 : 5'b01000;
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic m, input logic b, input logic [7:0] a);
    ev_valid = 1'b1; ev_kind = k; excl = m; byp = b; ev_addr = a;
  endtask

  task automatic verify(input string tag, input logic [1:0] k, input logic m, input logic b,
                        input logic [7:0] a);
    logic [4:0] e;
    e = expect_route(k, m, b);
    if (e[4] || e[2]) exp_ins = (exp_ins < CMAX) ? exp_ins + 1 : CMAX;
    if (e[0]) exp_drop = (exp_drop < CMAX) ? exp_drop + 1 : CMAX;
    check(tag, {l3_ins, l2_inst, l3_inst, l3_inv, drp}, e);
    check({tag, " addr R9"}, addr, a);
    check({tag, " ins_cnt R11"}, ins_cnt, exp_ins);
    check({tag, " drop_cnt R11"}, drop_cnt, exp_drop);
  endtask

  task automatic send(input string tag, input logic [1:0] k, input logic m, input logic b,
                      input logic [7:0] a);
    @(negedge clk);
    drive(k, m, b, a);
    @(posedge clk);
    @(negedge clk);
    verify(tag, k, m, b, a);
    ev_valid = 1'b0;
  endtask

  task automatic test_reset;
    check("reset strobes R12", {l3_ins, l2_inst, l3_inst, l3_inv, drp}, 0);
    check("reset addr R12", addr, 0);
    check("reset counts R12", {ins_cnt, drop_cnt}, 0);
  endtask

  task automatic test_noninc;
    send("clean mode0 R1", 2'd0, 1'b0, 1'b0, 8'h11);
    send("fill mode0 R2", 2'd2, 1'b0, 1'b0, 8'h12);
    send("hit mode0 R3", 2'd3, 1'b0, 1'b0, 8'h13);
    send("dirty mode0 R7", 2'd1, 1'b0, 1'b0, 8'h14);
  endtask

  task automatic test_excl;
    send("clean mode1 R4", 2'd0, 1'b1, 1'b0, 8'h21);
    send("fill mode1 R5", 2'd2, 1'b1, 1'b0, 8'h22);
    send("hit mode1 R6", 2'd3, 1'b1, 1'b0, 8'h23);
    send("dirty mode1 R7", 2'd1, 1'b1, 1'b0, 8'h24);
  endtask

  task automatic test_bypass;
    send("clean mode1 bypass R8", 2'd0, 1'b1, 1'b1, 8'h31);
    send("dirty mode1 bypass R7", 2'd1, 1'b1, 1'b1, 8'h32);
    send("clean mode0 bypass R8", 2'd0, 1'b0, 1'b1, 8'h33);
    send("fill mode1 bypass R8", 2'd2, 1'b1, 1'b1, 8'h34);
    send("hit mode1 bypass R8", 2'd3, 1'b1, 1'b1, 8'h35);
    send("fill mode0 bypass R8", 2'd2, 1'b0, 1'b1, 8'h36);
  endtask

  task automatic test_idle;
    @(negedge clk);
    ev_valid = 1'b0; ev_kind = 2'd2;
    @(posedge clk);
    @(negedge clk);
    check("idle quiet R9", {l3_ins, l2_inst, l3_inst, l3_inv, drp}, 0);
    check("idle counts hold R11", {ins_cnt, drop_cnt}, {exp_ins[CNT_W-1:0], exp_drop[CNT_W-1:0]});
  endtask

  task automatic test_switch;
    @(negedge clk);
    drive(2'd2, 1'b0, 1'b0, 8'h41);
    @(posedge clk); @(negedge clk);
    verify("b2b fill mode0 R10", 2'd2, 1'b0, 1'b0, 8'h41);
    drive(2'd2, 1'b1, 1'b0, 8'h42);
    @(posedge clk); @(negedge clk);
    verify("b2b fill mode1 R10", 2'd2, 1'b1, 1'b0, 8'h42);
    drive(2'd3, 1'b0, 1'b0, 8'h43);
    @(posedge clk); @(negedge clk);
    verify("b2b hit mode0 R10", 2'd3, 1'b0, 1'b0, 8'h43);
    drive(2'd3, 1'b1, 1'b0, 8'h44);
    @(posedge clk); @(negedge clk);
    verify("b2b hit mode1 R10", 2'd3, 1'b1, 1'b0, 8'h44);
    ev_valid = 1'b0;
  endtask

  task automatic test_saturate;
    for (int i = 0; i < 10; i++) send("drop sat R11", 2'd0, 1'b0, 1'b0, 8'h50 + 8'(i));
    for (int i = 0; i < 10; i++) send("ins sat R11", 2'd1, 1'b1, 1'b0, 8'h60 + 8'(i));
    check("drop count at max R11", drop_cnt, CMAX);
    check("ins count at max R11", ins_cnt, CMAX);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_noninc();
    test_excl();
    test_bypass();
    test_idle();
    test_switch();
    test_saturate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule